// File: doc/BRIEF.md
# Three-Multiply Complex Twiddle Multiplier

This block forms the product of a complex signed sample and a complex twiddle constant that is fixed when the block is elaborated. It needs three real constant multiplications rather than four. The twiddle is given as two signed integers already scaled by 2^S. At elaboration the block splits each part into a sign and a magnitude, and it also forms the combined coefficient (real part plus imaginary part) as a constant. No arithmetic on the coefficient happens at run time.

Each of the three real products is built as a shift-and-add tree over the set bits of a constant magnitude. Where fewer adders result, the tree is built over the complemented magnitude instead. The coefficient sign is applied afterwards by negation. A pre-add stage registers the two input combinations and the delayed real input. A second register stage holds the combined results. The outputs have one more bit than the input width plus S, which is enough for every input value. Rescaling by 2^-S and the butterfly add and subtract belong to the surrounding datapath and are not part of this block.

Top module: `twiddle_mul3`

## Requirements
- R1: When out_vld is 1, out_re equals in_re*WR - in_im*WI exactly, using the in_re and in_im values presented two cycles earlier. All values are two's complement integers, and WR and WI are the twiddle parts scaled by 2^S.
- R2: When out_vld is 1, out_im equals in_re*WI + in_im*WR exactly, using the inputs presented two cycles earlier.
- R3: out_re and out_im are M+S+1 bits wide. They never overflow for any input, including both inputs at -2^(M-1), for any twiddle with |WR| and |WI| at most 2^S and |WR|+|WI| below 2^(S+1).
- R4: out_vld equals in_vld delayed by exactly two clock cycles. A new sample is accepted on every cycle, and samples sent back to back or with gaps each produce their own result.
- R5: While rst_n is 0, out_vld, out_re and out_im are 0. After rst_n returns to 1, out_vld stays 0 until a valid input has passed through both register stages.
- R6: Twiddles with a negative real part, a negative imaginary part or a zero combined coefficient (for example 135 degrees, 180 degrees and -45 degrees) give results that meet R1 and R2.
- R7: Twiddles at 0, 45 and 90 degrees, where one coefficient magnitude is zero or a full power of two, give results that meet R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample valid |
| in_re | input | M | Real part of the input sample, signed |
| in_im | input | M | Imaginary part of the input sample, signed |
| out_vld | output | 1 | Result valid |
| out_re | output | M+S+1 | Real part of the product, signed |
| out_im | output | M+S+1 | Imaginary part of the product, signed |

## Verification
Each result and its valid flag are due two clock edges after the input is presented. The first edge captures the pre-add stage and the second captures the combined products. The bench drives each input on a falling edge and keeps a two-deep history of what it drove. On every later falling edge it compares out_vld, out_re and out_im against the history entry from two falling edges back. Every 4-bit input pair is streamed through six instances, one per twiddle angle: once back to back and once with gaps in in_vld. A reset applied mid-stream is checked on the next falling edge.

// File: rtl/twid_pkg.sv
package twid_pkg;

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic int popcnt(input int unsigned v);
      int c;
      c = 0;
      for (int i = 0; i < 32; i++) c += int'(v[i]);
      return c;
   endfunction

endpackage

// File: rtl/twid_shift_add.sv
module twid_shift_add #(
   parameter int          IW   = 8,
   parameter int          CW   = 7,
   parameter int unsigned CMAG = 0,
   parameter bit          NEG  = 1'b0,
   parameter int          OW   = 16
) (
   input  logic signed [IW-1:0] x,
   output logic signed [OW-1:0] p
);
   localparam logic [CW-1:0] CB  = CW'(CMAG);
   localparam int            HW  = twid_pkg::popcnt(CMAG);
   localparam bit            CPL = (2 * HW) > (CW + 2);

   if (OW < IW + CW + 1) begin : g_bad_ow
      $error("twid_shift_add: OW too small for IW+CW+1");
   end
   if (CMAG >= (1 << CW)) begin : g_bad_cmag
      $error("twid_shift_add: CMAG does not fit in CW bits");
   end

   logic signed [OW-1:0] xe;
   logic signed [OW-1:0] mag_p;

   assign xe = {{(OW-IW){x[IW-1]}}, x};

   if (CPL) begin : g_cpl
      always_comb begin
         mag_p = (xe <<< CW) - xe;
         for (int i = 0; i < CW; i++) begin
            if (!CB[i]) mag_p = mag_p - (xe <<< i);
         end
      end
   end else begin : g_direct
      always_comb begin
         mag_p = '0;
         for (int i = 0; i < CW; i++) begin
            if (CB[i]) mag_p = mag_p + (xe <<< i);
         end
      end
   end

   if (NEG) begin : g_neg
      assign p = -mag_p;
   end else begin : g_pos
      assign p = mag_p;
   end
endmodule

// File: rtl/twid_preadd.sv
module twid_preadd #(
   parameter int M = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic signed [M-1:0] in_re,
   input  logic signed [M-1:0] in_im,
   output logic                vld_q,
   output logic signed [M-1:0] re_q,
   output logic signed [M:0]   sum_q,
   output logic signed [M:0]   dif_q
);
   logic signed [M:0] re_x;
   logic signed [M:0] im_x;

   assign re_x = {in_re[M-1], in_re};
   assign im_x = {in_im[M-1], in_im};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         re_q  <= '0;
         sum_q <= '0;
         dif_q <= '0;
      end else begin
         vld_q <= in_vld;
         re_q  <= in_re;
         sum_q <= re_x + im_x;
         dif_q <= im_x - re_x;
      end
   end
endmodule

// File: rtl/twiddle_mul3.sv
module twiddle_mul3 #(
   parameter int M  = 8,
   parameter int S  = 6,
   parameter int WR = 45,
   parameter int WI = 45
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_vld,
   input  logic signed [M-1:0]   in_re,
   input  logic signed [M-1:0]   in_im,
   output logic                  out_vld,
   output logic signed [M+S:0]   out_re,
   output logic signed [M+S:0]   out_im
);
   localparam int OW      = M + S + 1;
   localparam int PW      = M + S + 3;
   localparam int AW      = M + 1;
   localparam int WRI     = WR + WI;
   localparam int WR_MAG  = twid_pkg::iabs(WR);
   localparam int WI_MAG  = twid_pkg::iabs(WI);
   localparam int WRI_MAG = twid_pkg::iabs(WRI);
   localparam int UNITY   = 1 << S;

   if (M < 2 || S < 1) begin : g_bad_size
      $error("twiddle_mul3: M must be >= 2 and S >= 1");
   end
   if (WR_MAG > UNITY || WI_MAG > UNITY) begin : g_bad_part
      $error("twiddle_mul3: twiddle part exceeds 2^S");
   end
   if (WR_MAG + WI_MAG >= 2 * UNITY) begin : g_bad_sum
      $error("twiddle_mul3: |WR|+|WI| must stay below 2^(S+1)");
   end

   logic                vld_q;
   logic signed [M-1:0] re_q;
   logic signed [AW-1:0] sum_q;
   logic signed [AW-1:0] dif_q;

   twid_preadd #(.M(M)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .in_vld(in_vld),
      .in_re (in_re),
      .in_im (in_im),
      .vld_q (vld_q),
      .re_q  (re_q),
      .sum_q (sum_q),
      .dif_q (dif_q)
   );

   logic signed [PW-1:0] p_comb;
   logic signed [PW-1:0] p_im;
   logic signed [PW-1:0] p_re;

   twid_shift_add #(
      .IW(M), .CW(S+2), .CMAG(WRI_MAG), .NEG(WRI < 0), .OW(PW)
   ) u_mul_comb (
      .x(re_q),
      .p(p_comb)
   );

   twid_shift_add #(
      .IW(AW), .CW(S+1), .CMAG(WI_MAG), .NEG(WI < 0), .OW(PW)
   ) u_mul_im (
      .x(sum_q),
      .p(p_im)
   );

   twid_shift_add #(
      .IW(AW), .CW(S+1), .CMAG(WR_MAG), .NEG(WR < 0), .OW(PW)
   ) u_mul_re (
      .x(dif_q),
      .p(p_re)
   );

   logic signed [PW-1:0] re_full;
   logic signed [PW-1:0] im_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         re_full <= '0;
         im_full <= '0;
      end else begin
         out_vld <= vld_q;
         re_full <= p_comb - p_im;
         im_full <= p_comb + p_re;
      end
   end

   assign out_re = re_full[OW-1:0];
   assign out_im = im_full[OW-1:0];
endmodule

// File: rtl/twid_mul3_chk.sv
module twid_mul3_chk #(
   parameter int M  = 8,
   parameter int S  = 6,
   parameter int WR = 45,
   parameter int WI = 45
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_vld,
   input logic signed [M-1:0]   in_re,
   input logic signed [M-1:0]   in_im,
   input logic                  out_vld,
   input logic signed [M+S:0]   out_re,
   input logic signed [M+S:0]   out_im,
   input logic signed [M+S+2:0] re_full,
   input logic signed [M+S+2:0] im_full
);
   localparam int OW = M + S + 1;
   localparam int PW = M + S + 3;

   longint ref_re;
   longint ref_im;

   assign ref_re = longint'(in_re) * longint'(WR) - longint'(in_im) * longint'(WI);
   assign ref_im = longint'(in_re) * longint'(WI) + longint'(in_im) * longint'(WR);

   AST_RE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 (longint'(out_re) == $past(ref_re, 2))); // R1

   AST_IM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 (longint'(out_im) == $past(ref_im, 2))); // R2

   AST_NO_OVERFLOW_RE: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ((&re_full[PW-1:OW-1]) || !(|re_full[PW-1:OW-1]))); // R3

   AST_NO_OVERFLOW_IM: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> ((&im_full[PW-1:OW-1]) || !(|im_full[PW-1:OW-1]))); // R3

   AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 out_vld); // R4

   AST_VLD_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |-> ##2 !out_vld); // R4

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (!out_vld && out_re == '0 && out_im == '0); // R5
      end
   end
endmodule

bind twiddle_mul3 twid_mul3_chk #(.M(M), .S(S), .WR(WR), .WI(WI)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .in_vld (in_vld),
   .in_re  (in_re),
   .in_im  (in_im),
   .out_vld(out_vld),
   .out_re (out_re),
   .out_im (out_im),
   .re_full(re_full),
   .im_full(im_full)
);

// File: tb/tb_twiddle_mul3.sv
`timescale 1ns/1ps
module tb_twiddle_mul3;
   localparam int M  = 4;
   localparam int S  = 6;
   localparam int OW = M + S + 1;
   localparam int NT = 6;

   function automatic int tw_re(input int g);
      case (g)
         0: return 64;
         1: return 45;
         2: return 0;
         3: return -45;
         4: return -64;
         default: return 45;
      endcase
   endfunction

   function automatic int tw_im(input int g);
      case (g)
         0: return 0;
         1: return 45;
         2: return 64;
         3: return 45;
         4: return 0;
         default: return -45;
      endcase
   endfunction

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic signed [M-1:0] in_re = '0;
   logic signed [M-1:0] in_im = '0;
   logic                 o_vld [NT];
   logic signed [OW-1:0] o_re  [NT];
   logic signed [OW-1:0] o_im  [NT];

   always #5 clk = ~clk;

   for (genvar g = 0; g < NT; g++) begin : g_tw
      twiddle_mul3 #(.M(M), .S(S), .WR(tw_re(g)), .WI(tw_im(g))) dut (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_vld (in_vld),
         .in_re  (in_re),
         .in_im  (in_im),
         .out_vld(o_vld[g]),
         .out_re (o_re[g]),
         .out_im (o_im[g])
      );
   end

   int  nchk = 0;
   int  nbad = 0;
   bit  done = 1'b0;

   bit              h_vld [2];
   logic signed [M-1:0] h_re [2];
   logic signed [M-1:0] h_im [2];

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic hist_clear();
      for (int j = 0; j < 2; j++) begin
         h_vld[j] = 1'b0;
         h_re[j]  = '0;
         h_im[j]  = '0;
      end
   endtask

   // compare outputs with the sample driven two falling edges ago
   task automatic check_due(input string tag);
      for (int g = 0; g < NT; g++) begin
         chk({tag, " R4 vld"}, longint'(o_vld[g]), longint'(h_vld[1]));
         if (h_vld[1]) begin
            longint er;
            longint ei;
            er = longint'(h_re[1]) * tw_re(g) - longint'(h_im[1]) * tw_im(g);
            ei = longint'(h_re[1]) * tw_im(g) + longint'(h_im[1]) * tw_re(g);
            if (g == 3 || g == 4 || g == 5) begin
               chk({tag, " R6 R1 re"}, longint'(o_re[g]), er);
               chk({tag, " R6 R2 im"}, longint'(o_im[g]), ei);
            end else begin
               chk({tag, " R7 R1 re"}, longint'(o_re[g]), er);
               chk({tag, " R7 R2 im"}, longint'(o_im[g]), ei);
            end
         end
      end
   endtask

   task automatic drive(input bit v, input logic [7:0] pat);
      in_vld   = v;
      in_re    = pat[7:4];
      in_im    = pat[3:0];
      h_vld[1] = h_vld[0];
      h_re[1]  = h_re[0];
      h_im[1]  = h_im[0];
      h_vld[0] = v;
      h_re[0]  = pat[7:4];
      h_im[0]  = pat[3:0];
   endtask

   // full sweep of 4-bit pairs; gap_mod 0 means back to back
   task automatic sweep(input int gap_mod, input string tag);
      for (int k = 0; k < 258; k++) begin
         @(negedge clk);
         check_due(tag);
         if (k < 256) drive(gap_mod == 0 || (k % gap_mod) != 2, 8'(k));
         else drive(1'b0, 8'h00);
      end
   endtask

   initial begin
      hist_clear();
      // R5: outputs held clear in reset even with valid input
      in_vld = 1'b1;
      in_re  = 4'sd7;
      in_im  = -4'sd8;
      repeat (3) @(negedge clk);
      for (int g = 0; g < NT; g++) begin
         chk("R5 reset vld", longint'(o_vld[g]), 0);
         chk("R5 reset re", longint'(o_re[g]), 0);
         chk("R5 reset im", longint'(o_im[g]), 0);
      end
      in_vld = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int g = 0; g < NT; g++)
         chk("R5 idle after reset", longint'(o_vld[g]), 0);

      // R1 R2 R3 R4: back to back over all pairs including -8,-8 extremes
      sweep(0, "stream");
      // R4: same sweep with holes in the valid pattern
      sweep(5, "gaps");

      // R3: extreme corners explicitly, back to back
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check_due("R3 corner");
         case (k)
            0: drive(1'b1, 8'h88);
            1: drive(1'b1, 8'h77);
            2: drive(1'b1, 8'h87);
            3: drive(1'b1, 8'h78);
            default: drive(1'b0, 8'h00);
         endcase
      end

      // R5: reset mid-stream clears everything on the next falling edge
      @(negedge clk);
      drive(1'b1, 8'h88);
      @(negedge clk);
      drive(1'b1, 8'h77);
      rst_n = 1'b0;
      @(negedge clk);
      for (int g = 0; g < NT; g++) begin
         chk("R5 midreset vld", longint'(o_vld[g]), 0);
         chk("R5 midreset re", longint'(o_re[g]), 0);
      end
      in_vld = 1'b0;
      hist_clear();
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check_due("R5 post");
         drive(1'b0, 8'h00);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule